// File: doc/BRIEF.md
# Wormhole Flit Link Controller

This block sits at one output link of a router and steers wormhole traffic onto it from several input ports. A message travels as a train of short flits. The first flit opens the message and claims the link. The flits after it follow one by one. The last flit closes the message and frees the link. While a message owns the link, flits from every other input wait in place. Nothing larger than one flit is ever stored.

Every flit moves across a boundary with a four-phase request/acknowledge exchange. This holds on each input side and on the output side. There is a single one-flit output stage. When the next node delays its acknowledge, that stage stays full. The owner's next flit then receives no acknowledge, and the stall reaches back along the path with no flit lost.

Each flit is `PAYLOAD_W + 2` bits wide. The top two bits hold the flit kind and the lower bits hold the payload.

Top module: `wh_link_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_req` is 0 and every bit of `in_ack` is 0.
- R2: A flit leaves on `out_flit` exactly as it was accepted, kind bits and payload unchanged. The kind field sits in bits [PAYLOAD_W+1:PAYLOAD_W], coded 2'b00 body, 2'b01 head, 2'b10 tail and 2'b11 single-flit message. `out_req` only rises in a cycle where some input acknowledge has just risen.
- R3: An input acknowledge rises only after that input's request was seen high. It stays high while the request stays high, and it falls at the first clock edge after the request drops.
- R4: `out_req` holds, with `out_flit` stable, until `out_ack` is seen. It falls at the next edge, and it does not rise again before `out_ack` has been seen low.
- R5: When the link is free and heads arrive on several inputs at once, the input with the lowest index is accepted first. Only one input is accepted per cycle.
- R6: While the link is reserved, a head flit on any other input is not acknowledged.
- R7: On a free link, a body or tail flit is ignored. It gets no acknowledge and produces no `out_req`.
- R8: Accepting a tail clears the reservation in the same cycle. A head that was waiting on another input is accepted as soon as the output stage has drained.
- R9: While the next node withholds `out_ack`, the owner's next flit is not acknowledged. Once the stall ends, every flit still arrives.
- R10: A single-flit message claims the link and releases it on its own acceptance, so a following head from another input is accepted without any tail.
- R11: The flits of one message leave the link in the order they were sent. No flit of another message appears between its head and its tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | NUM_IN | Per-input request, held with the flit until acknowledged |
| in_flit | input | NUM_IN*(PAYLOAD_W+2) | Per-input flit; input i occupies bits [i*(PAYLOAD_W+2) +: PAYLOAD_W+2] |
| in_ack | output | NUM_IN | Per-input acknowledge |
| out_req | output | 1 | Request toward the next node |
| out_flit | output | PAYLOAD_W+2 | Flit offered to the next node |
| out_ack | input | 1 | Acknowledge from the next node |

## Verification
Two things can coincide here. A tail can close the current owner's reservation while a head from a rival input is already waiting. The bench provokes this by raising the rival head while the owner's message is still open. It then confirms that the rival gets no acknowledge before the tail, and that it is accepted within a few cycles after the tail. Two heads raised on the same clock edge exercise the other coincidence, arbitration and claim at once. The first acknowledge must go to input 0. The output scoreboard then judges order and non-interleaving by the source number carried in each payload.

// File: rtl/wh_link_pkg.sv
package wh_link_pkg;

    // Kind field: bit 0 opens a message, bit 1 closes it.
    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    typedef enum logic [1:0] {
        TX_EMPTY = 2'b00,
        TX_OFFER = 2'b01,
        TX_DRAIN = 2'b10
    } tx_state_e;

    function automatic logic kind_opens(input logic [1:0] k);
        return k[0];
    endfunction

    function automatic logic kind_closes(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wh_rx_port.sv
module wh_rx_port (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic take,
    output logic ack,
    output logic pending
);
    // Four-phase receiver: acknowledge rises on take, falls once req is gone.
    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
        end else if (take) begin
            ack <= 1'b1;
        end else if (!req) begin
            ack <= 1'b0;
        end
    end

    assign pending = req & ~ack;
endmodule

// File: rtl/wh_claim.sv
module wh_claim
    import wh_link_pkg::*;
#(
    parameter int unsigned NUM_IN = 2,
    localparam int unsigned IDW = idx_width(NUM_IN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_IN-1:0]     pending,
    input  logic [2*NUM_IN-1:0]   kind_bus,
    input  logic                  stage_free,
    output logic [NUM_IN-1:0]     grant,
    output logic [IDW-1:0]        sel_idx
);
    logic           reserved;
    logic [IDW-1:0] owner;
    logic           win_any;
    logic [IDW-1:0] win_idx;
    logic [1:0]     sel_kind;

    // Lowest index holding an opening flit wins a free link.
    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pending[i] && kind_opens(kind_bus[2*i +: 2])) begin
                win_any = 1'b1;
                win_idx = IDW'(i);
            end
        end
    end

    assign sel_idx  = reserved ? owner : win_idx;
    assign sel_kind = kind_bus[2*int'(sel_idx) +: 2];

    always_comb begin
        grant = '0;
        if (stage_free) begin
            if (reserved) begin
                grant[sel_idx] = pending[sel_idx];
            end else if (win_any) begin
                grant[sel_idx] = 1'b1;
            end
        end
    end

    // Reservation lives from the opening flit to the closing flit.
    always_ff @(posedge clk) begin
        if (rst) begin
            reserved <= 1'b0;
            owner    <= '0;
        end else if (|grant) begin
            reserved <= ~kind_closes(sel_kind);
            owner    <= sel_idx;
        end
    end
endmodule

// File: rtl/wh_tx_stage.sv
module wh_tx_stage
    import wh_link_pkg::*;
#(
    parameter int unsigned FW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] load_flit,
    input  logic          out_ack,
    output logic          out_req,
    output logic [FW-1:0] out_flit,
    output logic          free
);
    tx_state_e     state;
    logic [FW-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_EMPTY;
            held  <= '0;
        end else begin
            case (state)
                TX_EMPTY: if (load) begin
                    state <= TX_OFFER;
                    held  <= load_flit;
                end
                TX_OFFER: if (out_ack)  state <= TX_DRAIN;
                TX_DRAIN: if (!out_ack) state <= TX_EMPTY;
                default:                state <= TX_EMPTY;
            endcase
        end
    end

    assign out_req  = (state == TX_OFFER);
    assign out_flit = held;
    assign free     = (state == TX_EMPTY);
endmodule

// File: rtl/wh_link_ctrl.sv
module wh_link_ctrl
    import wh_link_pkg::*;
#(
    parameter int unsigned NUM_IN    = 2,
    parameter int unsigned PAYLOAD_W = 16,
    localparam int unsigned FLIT_W   = PAYLOAD_W + 2,
    localparam int unsigned IDW      = idx_width(NUM_IN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IN-1:0]          in_req,
    input  logic [NUM_IN*FLIT_W-1:0]   in_flit,
    output logic [NUM_IN-1:0]          in_ack,
    output logic                       out_req,
    output logic [FLIT_W-1:0]          out_flit,
    input  logic                       out_ack
);
    typedef struct packed {
        flit_kind_e            kind;
        logic [PAYLOAD_W-1:0]  data;
    } flit_t;

    logic [NUM_IN-1:0]   pending;
    logic [NUM_IN-1:0]   grant;
    logic [2*NUM_IN-1:0] kind_bus;
    logic [IDW-1:0]      sel_idx;
    logic                stage_free;
    flit_t               picked;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_rx
        flit_t f;
        assign f = flit_t'(in_flit[i*FLIT_W +: FLIT_W]);
        assign kind_bus[2*i +: 2] = f.kind;

        wh_rx_port u_rx (
            .clk     (clk),
            .rst     (rst),
            .req     (in_req[i]),
            .take    (grant[i]),
            .ack     (in_ack[i]),
            .pending (pending[i])
        );
    end

    wh_claim #(.NUM_IN(NUM_IN)) u_claim (
        .clk        (clk),
        .rst        (rst),
        .pending    (pending),
        .kind_bus   (kind_bus),
        .stage_free (stage_free),
        .grant      (grant),
        .sel_idx    (sel_idx)
    );

    assign picked = flit_t'(in_flit[int'(sel_idx)*FLIT_W +: FLIT_W]);

    wh_tx_stage #(.FW(FLIT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (|grant),
        .load_flit (picked),
        .out_ack   (out_ack),
        .out_req   (out_req),
        .out_flit  (out_flit),
        .free      (stage_free)
    );
endmodule

// File: rtl/wh_link_chk.sv
module wh_link_chk #(
    parameter int unsigned NUM_IN = 2,
    parameter int unsigned FW     = 18
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_IN-1:0] in_req,
    input logic [NUM_IN-1:0] in_ack,
    input logic              out_req,
    input logic [FW-1:0]     out_flit,
    input logic              out_ack
);
    for (genvar i = 0; i < NUM_IN; i++) begin : g_port
        p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (in_ack[i] && in_req[i]) |=> in_ack[i]);
        p_ack_fall_r3: assert property (@(posedge clk) disable iff (rst)
            (in_ack[i] && !in_req[i]) |=> !in_ack[i]);
        p_ack_cause_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(in_ack[i]) |-> $past(in_req[i]));
    end

    p_one_accept_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ack & ~$past(in_ack)));

    p_offer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> (out_req && $stable(out_flit)));

    p_offer_end_r4: assert property (@(posedge clk) disable iff (rst)
        (out_req && out_ack) |=> !out_req);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!out_req && out_ack) |=> !out_req);

    p_offer_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req) |-> (|(in_ack & ~$past(in_ack))));
endmodule

bind wh_link_ctrl wh_link_chk #(.NUM_IN(NUM_IN), .FW(PAYLOAD_W + 2)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_flit (out_flit),
    .out_ack  (out_ack)
);

// File: tb/tb_wh_link_ctrl.sv
module tb_wh_link_ctrl;
    localparam int N  = 2;
    localparam int PW = 16;
    localparam int FW = PW + 2;
    localparam logic [1:0] K_BODY = 2'b00, K_HEAD = 2'b01, K_TAIL = 2'b10, K_SOLO = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]    in_req_r = '0;
    logic [FW-1:0]   in_flit_r [N];
    logic [N*FW-1:0] in_flit_bus;
    logic [N-1:0]    in_ack;
    logic            out_req;
    logic [FW-1:0]   out_flit;
    logic            out_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    int rx_delay = 0;
    logic [FW-1:0] exp_q [$];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) in_flit_bus[i*FW +: FW] = in_flit_r[i];
    end

    wh_link_ctrl #(.NUM_IN(N), .PAYLOAD_W(PW)) dut (
        .clk(clk), .rst(rst), .in_req(in_req_r), .in_flit(in_flit_bus),
        .in_ack(in_ack), .out_req(out_req), .out_flit(out_flit), .out_ack(out_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] mk(input logic [1:0] k, input int src, input int seq);
        return {k, 4'(src), 12'(seq)};
    endfunction

    // Driver: four-phase send, expectation queued once accepted.
    task automatic send_flit(input int p, input logic [FW-1:0] f);
        @(negedge clk);
        in_flit_r[p] = f;
        in_req_r[p]  = 1'b1;
        do @(negedge clk); while (!in_ack[p]);
        exp_q.push_back(f);
        in_req_r[p] = 1'b0;
        @(negedge clk);
        chk(in_ack[p] == 1'b0, "R3 ack falls after req drop", 32'(in_ack[p]), 0);
    endtask

    task automatic send_msg(input int p, input int bodies);
        send_flit(p, mk(K_HEAD, p, 0));
        for (int b = 1; b <= bodies; b++) send_flit(p, mk(K_BODY, p, b));
        send_flit(p, mk(K_TAIL, p, bodies + 1));
    endtask

    // Monitor / downstream receiver with scoreboard and interleave check.
    initial begin : monitor
        logic [FW-1:0] got;
        logic [FW-1:0] exp;
        bit open_msg = 0;
        logic [3:0] open_src = '0;
        forever begin
            @(negedge clk); #1;
            if (!rst && out_req && !out_ack) begin
                got = out_flit;
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected flit", 32'(got), 0);
                end else begin
                    exp = exp_q.pop_front();
                    chk(got == exp, "R2 flit content/order", 32'(got), 32'(exp));
                end
                case (got[FW-1 -: 2])
                    K_HEAD: begin
                        chk(!open_msg, "R11 head inside open message", 32'(open_msg), 0);
                        open_msg = 1; open_src = got[PW-1 -: 4];
                    end
                    K_SOLO: chk(!open_msg, "R11 solo inside open message", 32'(open_msg), 0);
                    default: begin
                        chk(open_msg && got[PW-1 -: 4] == open_src, "R11 interleave",
                            32'(got[PW-1 -: 4]), 32'(open_src));
                        if (got[FW-1 -: 2] == K_TAIL) open_msg = 0;
                    end
                endcase
                for (int d = 0; d < rx_delay; d++) begin
                    @(negedge clk); #1;
                    if (!(out_req && out_flit == got))
                        chk(0, "R4 offer not held", 32'(out_flit), 32'(got));
                end
                out_ack = 1'b1;
                @(negedge clk); #1;
                chk(!out_req, "R4 req drops after ack", 32'(out_req), 0);
                out_ack = 1'b0;
                @(negedge clk); #1;
                chk(!out_req, "R4 no req before ack low seen", 32'(out_req), 0);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int cnt;
        for (int i = 0; i < N; i++) in_flit_r[i] = '0;
        repeat (4) @(negedge clk);
        chk(out_req == 0 && in_ack == 0, "R1 reset outputs", {out_req, 30'd0, |in_ack}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_req == 0 && in_ack == 0, "R1 after reset", {out_req, 30'd0, |in_ack}, 0);

        // Plain message, fast receiver, then slower receiver on the other input.
        send_msg(0, 3);
        rx_delay = 3;
        send_msg(1, 2);
        rx_delay = 0;

        // R7: body and tail on a free link are ignored.
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_flit_r[1] = mk(k == 0 ? K_BODY : K_TAIL, 1, 99);
            in_req_r[1] = 1'b1;
            repeat (10) @(negedge clk);
            chk(in_ack[1] == 0 && out_req == 0, "R7 non-head ignored on free link",
                {out_req, 30'd0, in_ack[1]}, 0);
            in_req_r[1] = 1'b0;
        end
        repeat (3) @(negedge clk);

        // R6 / R8: rival head waits for the owner's tail.
        fork
            send_flit(1, mk(K_HEAD, 1, 0));
            begin
                send_flit(0, mk(K_HEAD, 0, 0));
                send_flit(0, mk(K_BODY, 0, 1));
                repeat (8) @(negedge clk);
                chk(in_ack[1] == 0, "R6 rival head refused while reserved", 32'(in_ack[1]), 0);
                send_flit(0, mk(K_BODY, 0, 2));
                send_flit(0, mk(K_TAIL, 0, 3));
                cnt = 0;
                while (!in_ack[1] && cnt < 12) begin @(negedge clk); cnt++; end
                chk(cnt < 12, "R8 waiting head accepted after tail", 32'(cnt), 12);
            end
        join
        send_flit(1, mk(K_TAIL, 1, 1));

        // R5 / R10: simultaneous single-flit messages.
        fork
            send_flit(0, mk(K_SOLO, 0, 7));
            send_flit(1, mk(K_SOLO, 1, 7));
            begin
                @(negedge clk);
                while (in_ack == 0) @(negedge clk);
                chk(in_ack == 2'b01, "R5 lowest index first", 32'(in_ack), 1);
                cnt = 0;
                while (!in_ack[1] && cnt < 12) begin @(negedge clk); cnt++; end
                chk(cnt < 12, "R10 solo releases link", 32'(cnt), 12);
            end
        join

        // R9: downstream stall holds the owner's next flit.
        rx_delay = 30;
        fork
            send_msg(0, 2);
            begin
                @(negedge clk);
                while (!out_req) @(negedge clk);
                repeat (10) @(negedge clk);
                chk(in_req_r[0] == 1 && in_ack[0] == 0, "R9 next flit stalled",
                    32'(in_ack[0]), 0);
            end
        join
        rx_delay = 0;

        cnt = 0;
        while ((exp_q.size() != 0 || out_req || out_ack) && cnt < 200) begin
            @(negedge clk); cnt++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all flits delivered", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule